// File: doc/BRIEF.md
# FIFO Threshold Monitor with Hysteresis

This block watches the fill level of two FIFOs and reports when either crosses a programmable limit. The import FIFO is expected never to fill, so the block flags when its depth climbs above an almost-full limit. The free-list FIFO is expected never to drain, so the block flags when its depth drops below an almost-empty limit. Each new crossing produces a single-cycle event pulse that feeds a saturating counter elsewhere in the chip.

All three limits arrive through one write-only configuration word. The third limit is a resume level for the free list. After a free-list event, the event path is disarmed. It is re-armed only once the free-list depth climbs back to the resume level. A depth that oscillates around the almost-empty limit therefore cannot inflate the counter. The resume level gates only the event pulse. Both flags always follow the plain comparisons.

Top module: `fifo_thresh_mon`

## Requirements
- R1: After reset, the almost-empty and resume limits are 0 and the almost-full limit is all ones. With those limits, `imp_afull`, `fl_aempty` and `thr_evt` all stay 0 for every depth, including an import depth of 511 and a free-list depth of 0.
- R2: A cycle with `cfg_we` high loads the limits from `cfg_wdata` on that edge: almost-empty from bits 8:0, almost-full from bits 17:9 and resume from bits 26:18. Bits 31:27 are ignored.
- R3: `imp_afull` is 1 in the cycle after an edge at which `imp_depth` was strictly greater than the almost-full limit, and 0 otherwise. A depth equal to the limit does not set it.
- R4: `fl_aempty` is 1 in the cycle after an edge at which `fl_depth` was strictly less than the almost-empty limit, and 0 otherwise. A depth equal to the limit does not set it.
- R5: An import crossing raises `thr_evt` for exactly one cycle, in the same cycle that `imp_afull` rises. A depth that stays above the limit gives no further pulses. The depth must first fall back to the limit or below before it can pulse again.
- R6: When the free-list event path is armed, a falling crossing raises `thr_evt` for one cycle, in the same cycle that `fl_aempty` rises.
- R7: The free-list event path is armed at reset and disarmed by a free-list event. It is re-armed at an edge where `fl_depth` is greater than or equal to the resume limit and no free-list event fires. While it is disarmed, free-list crossings produce no pulse.
- R8: The resume limit has no effect on `fl_aempty` or `imp_afull`. The flag still rises on a crossing that happens while the event path is disarmed.
- R9: An import crossing and a free-list crossing at the same edge produce one single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the limit word |
| cfg_wdata | input | 32 | Limit word: resume 26:18, almost-full 17:9, almost-empty 8:0 |
| imp_depth | input | 9 | Current import FIFO depth |
| fl_depth | input | 9 | Current free-list FIFO depth |
| imp_afull | output | 1 | Import depth above the almost-full limit (registered) |
| fl_aempty | output | 1 | Free-list depth below the almost-empty limit (registered) |
| thr_evt | output | 1 | One-cycle crossing event for the counter bank |

## Verification
The import depth is stepped across the almost-full limit from below, held above it, set equal to it, and crossed again. This separates a strict comparison from a non-strict one, and edge-triggered pulses from level-triggered ones.

The free-list depth is moved down through the almost-empty limit, back up to a level between the two limits, and down again. It is then raised to one below the resume limit and to exactly the resume limit before dipping once more. These runs show that re-arming needs the full resume level and that the flag ignores the armed state.

A simultaneous crossing on both FIFOs checks that the two sources merge into one pulse. A configuration word with its unused top bits set checks that those bits are dropped.

// File: rtl/fthm_pkg.sv
package fthm_pkg;
  localparam int unsigned THR_W_DEF = 9;
  localparam int unsigned CFG_W_DEF = 32;

  typedef enum int unsigned {
    FLD_AEMPTY = 0,
    FLD_AFULL  = 1,
    FLD_RESUME = 2
  } fld_e;

  localparam int unsigned NUM_FLD = 3;

  function automatic int unsigned fld_lsb(input fld_e f, input int unsigned w);
    return int'(f) * w;
  endfunction
endpackage

// File: rtl/fthm_cfg_reg.sv
module fthm_cfg_reg
  import fthm_pkg::*;
#(
  parameter int unsigned THR_W = THR_W_DEF,
  parameter int unsigned CFG_W = CFG_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [THR_W-1:0] aempty_thr,
  output logic [THR_W-1:0] afull_thr,
  output logic [THR_W-1:0] resume_thr
);
  localparam int unsigned AE_LSB = fld_lsb(FLD_AEMPTY, THR_W);
  localparam int unsigned AF_LSB = fld_lsb(FLD_AFULL, THR_W);
  localparam int unsigned RS_LSB = fld_lsb(FLD_RESUME, THR_W);
  localparam int unsigned USED_W = NUM_FLD * THR_W;

  logic [THR_W-1:0] ae_q, af_q, rs_q;
  logic [THR_W-1:0] ae_d, af_d, rs_d;

  // Only the packed fields are decoded; any upper bits are dropped.
  always_comb begin
    ae_d = wdata[AE_LSB +: THR_W];
    af_d = wdata[AF_LSB +: THR_W];
    rs_d = wdata[RS_LSB +: THR_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_q <= '0;
      af_q <= '1;
      rs_q <= '0;
    end else if (we) begin
      ae_q <= ae_d;
      af_q <= af_d;
      rs_q <= rs_d;
    end
  end

  assign aempty_thr = ae_q;
  assign afull_thr  = af_q;
  assign resume_thr = rs_q;

  if (USED_W > CFG_W) begin : g_bad_width
    $error("fthm_cfg_reg: configuration word too narrow for the fields");
  end
endmodule

// File: rtl/fthm_cross.sv
module fthm_cross #(
  parameter int unsigned W     = 9,
  parameter bit          ABOVE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] depth,
  input  logic [W-1:0] thr,
  output logic         flag_o,
  output logic         cross_o
);
  logic hit;
  logic flag_q;

  if (ABOVE) begin : g_above
    assign hit = depth > thr;
  end else begin : g_below
    assign hit = depth < thr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= hit;
  end

  // A crossing is a hit now against no hit at the previous edge.
  assign cross_o = hit & ~flag_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/fthm_rearm.sv
module fthm_rearm #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] depth,
  input  logic [W-1:0] resume_thr,
  input  logic         fire,
  output logic         armed_o
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (fire)                     armed_d = 1'b0;
    else if (depth >= resume_thr) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b1;
    else        armed_q <= armed_d;
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/fifo_thresh_mon.sv
module fifo_thresh_mon
  import fthm_pkg::*;
#(
  parameter int unsigned THR_W = THR_W_DEF,
  parameter int unsigned CFG_W = CFG_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [THR_W-1:0] imp_depth,
  input  logic [THR_W-1:0] fl_depth,
  output logic             imp_afull,
  output logic             fl_aempty,
  output logic             thr_evt
);
  logic [THR_W-1:0] ae_thr, af_thr, rs_thr;
  logic imp_cross, fl_cross;
  logic fl_armed, fl_fire;
  logic evt_d, evt_q;

  fthm_cfg_reg #(.THR_W(THR_W), .CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .aempty_thr(ae_thr), .afull_thr(af_thr), .resume_thr(rs_thr)
  );

  fthm_cross #(.W(THR_W), .ABOVE(1'b1)) u_imp (
    .clk(clk), .rst_n(rst_n), .depth(imp_depth), .thr(af_thr),
    .flag_o(imp_afull), .cross_o(imp_cross)
  );

  fthm_cross #(.W(THR_W), .ABOVE(1'b0)) u_fl (
    .clk(clk), .rst_n(rst_n), .depth(fl_depth), .thr(ae_thr),
    .flag_o(fl_aempty), .cross_o(fl_cross)
  );

  assign fl_fire = fl_cross & fl_armed;

  fthm_rearm #(.W(THR_W)) u_rearm (
    .clk(clk), .rst_n(rst_n), .depth(fl_depth), .resume_thr(rs_thr),
    .fire(fl_fire), .armed_o(fl_armed)
  );

  assign evt_d = imp_cross | fl_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_d;
  end

  assign thr_evt = evt_q;
endmodule

// File: rtl/fthm_checker.sv
module fthm_checker (
  input logic clk,
  input logic rst_n,
  input logic imp_afull,
  input logic fl_aempty,
  input logic thr_evt,
  input logic armed
);
  // R5
  imp_rise_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(imp_afull) |-> thr_evt);

  // R6
  armed_fall_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fl_aempty) && $past(armed)) |-> thr_evt);

  // R9
  evt_needs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_evt |-> ($rose(imp_afull) || $rose(fl_aempty)));

  // R7
  fl_evt_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_evt && $rose(fl_aempty) && !$rose(imp_afull)) |-> !armed);
endmodule

bind fifo_thresh_mon fthm_checker u_fthm_checker (
  .clk(clk), .rst_n(rst_n), .imp_afull(imp_afull),
  .fl_aempty(fl_aempty), .thr_evt(thr_evt), .armed(fl_armed)
);

// File: tb/fifo_thresh_mon_bench.sv
module fifo_thresh_mon_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [8:0]  imp_depth = '0;
  logic [8:0]  fl_depth = '0;
  logic        imp_afull, fl_aempty, thr_evt;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_thresh_mon u_fifo_thresh_mon (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .imp_depth(imp_depth), .fl_depth(fl_depth),
    .imp_afull(imp_afull), .fl_aempty(fl_aempty), .thr_evt(thr_evt)
  );

  task automatic chk(input string req, input logic af, input logic ae, input logic ev);
    checks++;
    if (imp_afull !== af || fl_aempty !== ae || thr_evt !== ev) begin
      fails++;
      $display("FAIL %s: afull/aempty/evt = %b%b%b expected %b%b%b",
               req, imp_afull, fl_aempty, thr_evt, af, ae, ev);
    end
  endtask

  task automatic step(input int imp, input int fl);
    imp_depth = 9'(imp);
    fl_depth  = 9'(fl);
    @(posedge clk);
    #1;
  endtask

  task automatic write_cfg(input logic [4:0] top, input int rs, input int af, input int ae);
    cfg_wdata = {top, 9'(rs), 9'(af), 9'(ae)};
    cfg_we = 1'b1;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset", 1'b0, 1'b0, 1'b0);
    step(511, 0);
    chk("R1 extreme depths", 1'b0, 1'b0, 1'b0);
    step(0, 200);
  endtask

  task automatic t_import();
    write_cfg(5'd0, 50, 100, 10);
    step(50, 200);  chk("R2 below limit", 1'b0, 1'b0, 1'b0);
    step(101, 200); chk("R5 import crossing", 1'b1, 1'b0, 1'b1);
    step(150, 200); chk("R5 held above", 1'b1, 1'b0, 1'b0);
    step(100, 200); chk("R3 equal to limit", 1'b0, 1'b0, 1'b0);
    step(101, 200); chk("R5 second crossing", 1'b1, 1'b0, 1'b1);
    step(0, 200);   chk("R3 cleared", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_freelist();
    step(0, 10);  chk("R4 equal to limit", 1'b0, 1'b0, 1'b0);
    step(0, 9);   chk("R6 free-list crossing", 1'b0, 1'b1, 1'b1);
    step(0, 9);   chk("R6 held below", 1'b0, 1'b1, 1'b0);
    step(0, 20);  chk("R4 recovered", 1'b0, 1'b0, 1'b0);
    step(0, 5);   chk("R8 flag while disarmed", 1'b0, 1'b1, 1'b0);
    step(0, 49);  chk("R7 just under resume", 1'b0, 1'b0, 1'b0);
    step(0, 5);   chk("R7 still disarmed", 1'b0, 1'b1, 1'b0);
    step(0, 50);  chk("R7 reach resume", 1'b0, 1'b0, 1'b0);
    step(0, 5);   chk("R7 rearmed pulse", 1'b0, 1'b1, 1'b1);
    step(0, 200);
  endtask

  task automatic t_both();
    step(101, 5); chk("R9 merged pulse", 1'b1, 1'b1, 1'b1);
    step(101, 5); chk("R9 single cycle", 1'b1, 1'b1, 1'b0);
    step(0, 200); chk("R9 idle", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_upper_bits();
    write_cfg(5'h1f, 50, 100, 10);
    step(100, 10);  chk("R2 upper bits ignored, at limits", 1'b0, 1'b0, 1'b0);
    step(101, 9);   chk("R2 upper bits ignored, crossing", 1'b1, 1'b1, 1'b1);
    step(0, 200);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_import();
        t_freelist();
        t_both();
        t_upper_bits();
      end
      begin
        repeat (2000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule